// File: doc/BRIEF.md
# Sleep Mode Wake Controller

This block governs when a CPU stops executing and when it starts again. Firmware requests sleep by writing the sleep bit. The controller then halts the CPU, stops the fast internal oscillator and forces the CPU clock selection onto the internal oscillator. While asleep it watches the pending interrupt flags through their mask bits. The first pending source whose mask bit is set ends the sleep. The global interrupt enable plays no part in this decision, so the block has no input for it. Firmware that does not want a source to wake the CPU must clear that source's mask bit.

After a wake, the fast oscillator restarts at once, but the CPU stays halted until three slow-clock ticks have arrived. The slow oscillator keeps running during sleep. The controller then raises a one-cycle resume indication. This lets the CPU run the instruction after its sleep instruction before any interrupt service routine. A power-on or watchdog reset event returns the controller to normal running in the next cycle, whatever state it is in, and clears the sleep bit.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After rst_n is released, the controller is running: cpu_halt=0, clk_sel_force=0, fast_osc_en=1, resume=0 and sleep_bit=0.
- R2: A sleep_set pulse while running causes, one cycle later, cpu_halt=1, sleep_bit=1, fast_osc_en=0 and clk_sel_force=1.
- R3: A sleep_set pulse while asleep, recovering or resuming has no effect. The controller stays in its current state (recovering stays recovering, resuming returns to running), and sleep_bit does not become 1.
- R4: While asleep, if any bit of irq_pend is 1 with the same bit of irq_mask set to 1, the next cycle has fast_osc_en=1 and sleep_bit=0, and cpu_halt stays 1. A pending bit whose mask bit is 0 leaves the controller asleep. No global interrupt enable takes part in this decision.
- R5: clk_sel_force is 1 exactly while cpu_halt is 1, both asleep and recovering.
- R6: During recovery, cpu_halt stays 1 until the third slow_tick counted after the wake. The cycle after that third tick is the resume cycle. Ticks that arrive while asleep are not counted.
- R7: resume is 1 for exactly one cycle, with cpu_halt=0 in that cycle. The next cycle returns to running with resume=0.
- R8: A por_evt or wdr_evt pulse in any state yields the running outputs and sleep_bit=0 in the next cycle. It takes priority over sleep_set in the same cycle. It discards any partial recovery count, so a later wake again needs three ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_set | input | 1 | One-cycle pulse: firmware writes 1 to the sleep bit |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| irq_pend | input | NUM_SRC | Per-source pending interrupt flags |
| irq_mask | input | NUM_SRC | Per-source interrupt mask bits, 1 = enabled |
| por_evt | input | 1 | Power-on reset event |
| wdr_evt | input | 1 | Watchdog reset event |
| cpu_halt | output | 1 | Holds the CPU off instruction execution |
| clk_sel_force | output | 1 | Forces the CPU clock select to the internal oscillator |
| fast_osc_en | output | 1 | Enable for the fast internal oscillator |
| resume | output | 1 | One-cycle pulse: run the post-sleep instruction first |
| sleep_bit | output | 1 | Current value of the sleep bit |

## Verification
The bench holds a masked pending interrupt during sleep. A design that ORed raw pending flags, or applied a global enable, would wake there or fail to wake. It sends slow ticks while the CPU is asleep and irregular gaps between ticks during recovery. A counter started at sleep entry, or one counting clock cycles, would release the CPU too early. It aborts a recovery part-way with a watchdog event and then sleeps again. A counter left uncleared would resume after fewer than three fresh ticks. It also sends sleep requests during recovery, during the resume cycle and together with a reset event. A design that accepted these would fall back asleep or skip the resume step.

// File: rtl/slp_pkg.sv
// Package slp_pkg
// Shared types for the sleep/wake controller. Assumes a two-bit state
// encoding is enough for the four controller phases.
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_RECOVER = 2'd2,
        ST_RESUME  = 2'd3
    } slp_state_e;

endpackage

// File: rtl/slp_wake_detect.sv
// Module slp_wake_detect
// Reduces the per-source pending flags, gated by their mask bits, to a
// single wake request. Assumes both vectors are synchronous to clk.
// There is deliberately no global-enable term.
module slp_wake_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic               wake
);

    logic [NUM_SRC-1:0] armed;

    // Gate every source by its own mask bit.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign armed[i] = pend[i] & mask[i];
    end

    // Any armed source requests a wake.
    assign wake = |armed;

endmodule

// File: rtl/slp_recover_timer.sv
// Module slp_recover_timer
// Counts slow-clock ticks during recovery. It flags done on the tick that
// completes RECOVER_TICKS. Assumes clear is high whenever the controller
// is outside recovery, so that every recovery starts from zero.
module slp_recover_timer #(
    parameter int RECOVER_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick_en,
    output logic done
);

    localparam int CW = (RECOVER_TICKS > 1) ? $clog2(RECOVER_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(RECOVER_TICKS - 1);

    logic [CW-1:0] cnt;

    // Tick counter: cleared outside recovery, counts qualified ticks inside.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick_en && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Completion is the qualified tick that lands on the final count.
    assign done = tick_en && (cnt == LAST);

endmodule

// File: rtl/slp_ctrl_fsm.sv
// Module slp_ctrl_fsm
// Sequencing state machine for the sleep/wake controller. It holds the
// sleep bit and decodes the CPU-facing controls from its state. Assumes
// that wake and rec_done are valid in the same cycle they are used, and
// that evt has priority over all other inputs.
module slp_ctrl_fsm
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic sleep_req,
    input  logic wake,
    input  logic rec_done,
    output logic in_recover,
    output logic sleep_bit,
    output logic cpu_halt,
    output logic clk_sel_force,
    output logic fast_osc_en,
    output logic resume
);

    slp_state_e st;

    // State and sleep bit update; reset events win over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || evt) begin
            st        <= ST_RUN;
            sleep_bit <= 1'b0;
        end else begin
            unique case (st)
                ST_RUN: begin
                    if (sleep_req) begin
                        st        <= ST_SLEEP;
                        sleep_bit <= 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wake) begin
                        st        <= ST_RECOVER;
                        sleep_bit <= 1'b0;
                    end
                end
                ST_RECOVER: begin
                    if (rec_done) begin
                        st <= ST_RESUME;
                    end
                end
                ST_RESUME: begin
                    st <= ST_RUN;
                end
                default: begin
                    st        <= ST_RUN;
                    sleep_bit <= 1'b0;
                end
            endcase
        end
    end

    // Output decode from the current state.
    always_comb begin
        cpu_halt      = 1'b0;
        clk_sel_force = 1'b0;
        fast_osc_en   = 1'b1;
        resume        = 1'b0;
        unique case (st)
            ST_RUN: begin
            end
            ST_SLEEP: begin
                cpu_halt      = 1'b1;
                clk_sel_force = 1'b1;
                fast_osc_en   = 1'b0;
            end
            ST_RECOVER: begin
                cpu_halt      = 1'b1;
                clk_sel_force = 1'b1;
            end
            ST_RESUME: begin
                resume = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Recovery flag feeds the tick counter.
    assign in_recover = (st == ST_RECOVER);

endmodule

// File: rtl/sleep_wake_ctrl.sv
// Module sleep_wake_ctrl
// Top of the sleep/wake controller. It combines the reset events, detects
// masked wake requests and times the slow-clock recovery before resuming
// the CPU. Assumes all inputs are synchronous to clk, and that slow_tick
// is already a single-cycle pulse in this clock domain.
module sleep_wake_ctrl #(
    parameter int NUM_SRC       = 8,
    parameter int RECOVER_TICKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_set,
    input  logic               slow_tick,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] irq_mask,
    input  logic               por_evt,
    input  logic               wdr_evt,
    output logic               cpu_halt,
    output logic               clk_sel_force,
    output logic               fast_osc_en,
    output logic               resume,
    output logic               sleep_bit
);

    logic evt;
    logic wake;
    logic in_recover;
    logic rec_done;
    logic tick_en;
    logic tmr_clear;

    // Either reset source returns the controller to running.
    assign evt       = por_evt | wdr_evt;
    assign tick_en   = in_recover & slow_tick & ~evt;
    assign tmr_clear = ~in_recover | evt;

    slp_wake_detect #(
        .NUM_SRC (NUM_SRC)
    ) u_wake (
        .pend (irq_pend),
        .mask (irq_mask),
        .wake (wake)
    );

    slp_recover_timer #(
        .RECOVER_TICKS (RECOVER_TICKS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick_en (tick_en),
        .done    (rec_done)
    );

    slp_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (evt),
        .sleep_req     (sleep_set),
        .wake          (wake),
        .rec_done      (rec_done),
        .in_recover    (in_recover),
        .sleep_bit     (sleep_bit),
        .cpu_halt      (cpu_halt),
        .clk_sel_force (clk_sel_force),
        .fast_osc_en   (fast_osc_en),
        .resume        (resume)
    );

endmodule

// File: rtl/sleep_wake_chk.sv
// Module sleep_wake_chk
// Property checker for sleep_wake_ctrl, attached by bind. Observes ports
// only. Asleep means cpu_halt=1 and fast_osc_en=0; recovering means
// cpu_halt=1 and fast_osc_en=1.
module sleep_wake_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_set,
    input logic               slow_tick,
    input logic [NUM_SRC-1:0] irq_pend,
    input logic [NUM_SRC-1:0] irq_mask,
    input logic               por_evt,
    input logic               wdr_evt,
    input logic               cpu_halt,
    input logic               clk_sel_force,
    input logic               fast_osc_en,
    input logic               resume,
    input logic               sleep_bit
);

    logic quiet;
    logic armed;
    assign quiet = ~por_evt & ~wdr_evt;
    assign armed = |(irq_pend & irq_mask);

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt && !resume && sleep_set && quiet) |=> (cpu_halt && !fast_osc_en && sleep_bit));

    p_no_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && fast_osc_en && quiet) |=> !sleep_bit);

    p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !fast_osc_en && armed && quiet) |=> (cpu_halt && fast_osc_en && !sleep_bit));

    p_stay_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !fast_osc_en && !armed && quiet) |=> (cpu_halt && !fast_osc_en));

    p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_force == cpu_halt);

    p_recover_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && fast_osc_en && !slow_tick && quiet) |=> (cpu_halt && fast_osc_en));

    p_resume_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (!resume && !cpu_halt));

    p_resume_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (!cpu_halt && fast_osc_en));

    p_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (por_evt || wdr_evt) |=> (!cpu_halt && !sleep_bit && !resume && fast_osc_en));

endmodule

bind sleep_wake_ctrl sleep_wake_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_set     (sleep_set),
    .slow_tick     (slow_tick),
    .irq_pend      (irq_pend),
    .irq_mask      (irq_mask),
    .por_evt       (por_evt),
    .wdr_evt       (wdr_evt),
    .cpu_halt      (cpu_halt),
    .clk_sel_force (clk_sel_force),
    .fast_osc_en   (fast_osc_en),
    .resume        (resume),
    .sleep_bit     (sleep_bit)
);

// File: tb/sleep_wake_ctrl_test.sv
// Directed bench for sleep_wake_ctrl. Inputs change 1 ns after a rising
// edge and outputs are sampled at that same point.
module sleep_wake_ctrl_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sleep_set = 1'b0;
    logic         slow_tick = 1'b0;
    logic [N-1:0] irq_pend = '0;
    logic [N-1:0] irq_mask = '0;
    logic         por_evt = 1'b0;
    logic         wdr_evt = 1'b0;
    logic         cpu_halt, clk_sel_force, fast_osc_en, resume, sleep_bit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    sleep_wake_ctrl #(.NUM_SRC(N), .RECOVER_TICKS(3)) uut (
        .clk (clk), .rst_n (rst_n), .sleep_set (sleep_set), .slow_tick (slow_tick),
        .irq_pend (irq_pend), .irq_mask (irq_mask), .por_evt (por_evt), .wdr_evt (wdr_evt),
        .cpu_halt (cpu_halt), .clk_sel_force (clk_sel_force), .fast_osc_en (fast_osc_en),
        .resume (resume), .sleep_bit (sleep_bit)
    );

    // Advance one clock and land 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [4:0] act, logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Pack of outputs {halt, force, fast, resume, sleep_bit}.
    function automatic logic [4:0] outs();
        return {cpu_halt, clk_sel_force, fast_osc_en, resume, sleep_bit};
    endfunction

    localparam logic [4:0] O_RUN  = 5'b00100;
    localparam logic [4:0] O_SLP  = 5'b11001;
    localparam logic [4:0] O_REC  = 5'b11100;
    localparam logic [4:0] O_RES  = 5'b00110;

    task automatic pulse_sleep();
        sleep_set = 1'b1; step(); sleep_set = 1'b0;
    endtask

    task automatic pulse_tick();
        slow_tick = 1'b1; step(); slow_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
        chk("R1", "reset outputs", outs(), O_RUN);
    endtask

    task automatic t_enter();
        pulse_sleep();
        chk("R2", "enter sleep", outs(), O_SLP);
        pulse_sleep();
        chk("R3", "sleep_set while asleep", outs(), O_SLP);
    endtask

    task automatic t_masked_and_early_ticks();
        irq_pend = 8'h0F; irq_mask = 8'hF0;
        step(); step();
        chk("R4", "masked pending keeps sleep", outs(), O_SLP);
        pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
        chk("R6", "ticks while asleep no wake", outs(), O_SLP);
    endtask

    task automatic t_wake_and_recover();
        irq_pend = 8'h80; irq_mask = 8'h80; step();
        irq_pend = '0;
        chk("R4", "unmasked wake -> recover", outs(), O_REC);
        pulse_sleep();
        chk("R3", "sleep_set in recovery ignored", outs(), O_REC);
        pulse_tick(); step(); step();
        chk("R6", "after 1 tick", outs(), O_REC);
        pulse_tick(); step();
        chk("R6", "after 2 ticks", outs(), O_REC);
        chk("R5", "force during recovery", {4'b0, clk_sel_force}, 5'b00001);
        pulse_tick();
        chk("R6", "third tick -> resume", outs(), O_RES);
        sleep_set = 1'b1; step(); sleep_set = 1'b0;
        chk("R7", "resume lasts one cycle", outs(), O_RUN);
        chk("R3", "sleep_set in resume ignored", outs(), O_RUN);
        chk("R5", "force released", {4'b0, clk_sel_force}, 5'b00000);
    endtask

    task automatic t_por_from_sleep();
        pulse_sleep();
        chk("R2", "re-enter sleep", outs(), O_SLP);
        por_evt = 1'b1; step(); por_evt = 1'b0;
        chk("R8", "por from sleep", outs(), O_RUN);
    endtask

    task automatic t_wdr_abort_recovery();
        irq_mask = 8'h01;
        pulse_sleep();
        irq_pend = 8'h01; step(); irq_pend = '0;
        chk("R4", "wake source 0", outs(), O_REC);
        pulse_tick(); pulse_tick();
        wdr_evt = 1'b1; step(); wdr_evt = 1'b0;
        chk("R8", "wdr aborts recovery", outs(), O_RUN);
        pulse_sleep();
        irq_pend = 8'h01; step(); irq_pend = '0;
        pulse_tick();
        chk("R8", "count restarted, 1 tick", outs(), O_REC);
        pulse_tick();
        chk("R8", "count restarted, 2 ticks", outs(), O_REC);
        pulse_tick();
        chk("R6", "fresh third tick resumes", outs(), O_RES);
        step();
        chk("R7", "back to running", outs(), O_RUN);
    endtask

    task automatic t_event_priority();
        sleep_set = 1'b1; por_evt = 1'b1; step();
        sleep_set = 1'b0; por_evt = 1'b0;
        chk("R8", "event beats sleep_set", outs(), O_RUN);
    endtask

    initial begin
        #1;
        t_reset();
        t_enter();
        t_masked_and_early_ticks();
        t_wake_and_recover();
        t_por_from_sleep();
        t_wdr_abort_recovery();
        t_event_priority();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule